// File: doc/BRIEF.md
# PWM Channel Edge Stagger

This block sits between four PWM modulator outputs and the power stage drivers. It shifts the switching edges of some outputs later in time by a programmable number of input clock cycles. As a result, the channels do not all switch on the same clock edge, which spreads the switching noise over time. The delay is set by a 4-bit value from 0 to 15 cycles. The absolute delay is that value times the input clock period.

A lane mode input picks how the delay is applied. In two-channel full-bridge mode, the third and fourth outputs move later by the setting as a pair. In three-channel mode (two half-bridge lanes plus one full-bridge pair), the outputs form a cascade: the second output lags the first by the setting, and the third/fourth pair lags the second by the setting again. The first output never gets any added delay.

The delay value and the lane mode are captured only while the global power-down input is high. While power-down is high, the outputs are held low and every delay pipeline is emptied. Software therefore sets up the block in power-down and then releases it.

Top module: `pwm_edge_stagger`

## Requirements
- R1: After reset, `dly_rd` reads 0 and the lane mode is two-channel, so with `pdn_all` low every `pwm_out` bit equals the matching `pwm_in` bit in the same cycle.
- R2: `pwm_out[0]` equals `pwm_in[0]` in the same cycle whenever `pdn_all` is low, in both lane modes and for any setting.
- R3: In two-channel mode (`mode_3ch` = 0 when captured), `pwm_out[1]` follows `pwm_in[1]` with no added delay, and `pwm_out[3:2]` equal the value `pwm_in[3:2]` had D cycles earlier, where D is the captured setting.
- R4: In three-channel mode (`mode_3ch` = 1 when captured), `pwm_out[1]` equals `pwm_in[1]` from D cycles earlier, and `pwm_out[3:2]` equal `pwm_in[3:2]` from 2·D cycles earlier.
- R5: When `wr_en` is high while `pdn_all` is high, `wr_data` is captured at that clock edge and shows on `dly_rd` from the next cycle.
- R6: When `wr_en` is high while `pdn_all` is low, the write is ignored: `dly_rd` and the delays applied to the outputs do not change.
- R7: `mode_3ch` is captured only while `pdn_all` is high. Changing it while `pdn_all` is low does not change the delays applied to the outputs.
- R8: While `pdn_all` is high, all four `pwm_out` bits are 0 whatever `pwm_in` is.
- R9: Every delay pipeline is cleared while `pdn_all` is high. After release, a delayed output stays 0 until its delay has elapsed, even if inputs were high during power-down.
- R10: A setting of 0 gives a combinational path with zero-cycle delay on all four outputs, in both lane modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; one delay step per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn_all | input | 1 | Global power-down; unlocks configuration, forces outputs low |
| mode_3ch | input | 1 | Lane mode: 0 two-channel full-bridge, 1 three-channel |
| wr_en | input | 1 | Write strobe for the delay setting |
| wr_data | input | 4 | New delay setting in cycles |
| dly_rd | output | 4 | Delay setting currently in use |
| pwm_in | input | 4 | Modulator outputs, bit 0 is the first output |
| pwm_out | output | 4 | Staggered outputs to the power stage |

## Verification
The main path is driven with a pseudo-random 4-bit pattern from an LFSR. This gives edges of every polarity, on every output, at irregular spacing, so a tap that is one cycle off, or a pair driven from the wrong lane, shows up as a mismatch. This pattern is run against a set of settings that includes 0, 1, a mid value and the maximum 15, in both lane modes. Comparing the three-channel cases at 15 with the two-channel cases tells the 2·D cascade apart from a single delay. Before each release the inputs are held all-high during power-down, so any stale pipeline content would appear in the first D cycles after release. In one run, a write and a mode flip are made while running, which separates an ignored update from a live one.

// File: rtl/pwm_stagger_pkg.sv
package pwm_stagger_pkg;

    typedef enum logic {
        LANE_2CH = 1'b0,
        LANE_3CH = 1'b1
    } lane_mode_e;

endpackage

// File: rtl/pwm_stagger_cfg.sv
module pwm_stagger_cfg
    import pwm_stagger_pkg::*;
#(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pdn,
    input  logic             mode_in,
    input  logic             wr_en,
    input  logic [DLY_W-1:0] wr_data,
    output logic [DLY_W-1:0] dly_o,
    output lane_mode_e       mode_o
);

    typedef struct packed {
        logic [DLY_W-1:0] dly;
        lane_mode_e       mode;
    } cfg_t;

    cfg_t st_d, st_q;

    // Configuration only moves while the block is powered down.
    always_comb begin
        st_d = st_q;
        if (pdn) begin
            st_d.mode = lane_mode_e'(mode_in);
            if (wr_en) begin
                st_d.dly = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{dly: '0, mode: LANE_2CH};
        end else begin
            st_q <= st_d;
        end
    end

    assign dly_o  = st_q.dly;
    assign mode_o = st_q.mode;

    assert_write_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pdn && wr_en) |=> (dly_o == $past(wr_data)));

    assert_write_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pdn |=> $stable(dly_o));

    assert_mode_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pdn |=> $stable(mode_o));

endmodule

// File: rtl/pwm_stagger_dline.sv
module pwm_stagger_dline #(
    parameter int WIDTH = 1,
    parameter int DEPTH = 15,
    parameter int TAP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [WIDTH-1:0] din,
    input  logic [TAP_W-1:0] tap,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] sh_d [DEPTH];
    logic [WIDTH-1:0] sh_q [DEPTH];

    always_comb begin
        sh_d[0] = clr ? '0 : din;
        for (int i = 1; i < DEPTH; i++) begin
            sh_d[i] = clr ? '0 : sh_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                sh_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                sh_q[i] <= sh_d[i];
            end
        end
    end

    // Tap 0 bypasses the register chain; tap N reads stage N-1.
    always_comb begin
        if (tap == '0) begin
            dout = din;
        end else if (int'(tap) > DEPTH) begin
            dout = sh_q[DEPTH-1];
        end else begin
            dout = sh_q[int'(tap) - 1];
        end
    end

    assert_clear_head_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sh_q[0] == '0));

    assert_clear_tail_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sh_q[DEPTH-1] == '0));

    assert_shift_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (sh_q[0] == $past(din)));

endmodule

// File: rtl/pwm_edge_stagger.sv
module pwm_edge_stagger
    import pwm_stagger_pkg::*;
#(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pdn_all,
    input  logic             mode_3ch,
    input  logic             wr_en,
    input  logic [DLY_W-1:0] wr_data,
    output logic [DLY_W-1:0] dly_rd,
    input  logic [3:0]       pwm_in,
    output logic [3:0]       pwm_out
);

    localparam int MAX_DLY = (1 << DLY_W) - 1;
    localparam int DEPTH_A = MAX_DLY;
    localparam int DEPTH_B = 2 * MAX_DLY;
    localparam int TAP_B_W = DLY_W + 1;

    logic [DLY_W-1:0]   dly_q;
    lane_mode_e         mode_q;
    logic [DLY_W-1:0]   tap_a;
    logic [TAP_B_W-1:0] tap_b;
    logic               lane2_dly;
    logic [1:0]         pair_dly;

    pwm_stagger_cfg #(.DLY_W(DLY_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .pdn     (pdn_all),
        .mode_in (mode_3ch),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .dly_o   (dly_q),
        .mode_o  (mode_q)
    );

    // Lane 2 is delayed only in the cascaded mode; the pair doubles there.
    always_comb begin
        if (mode_q == LANE_3CH) begin
            tap_a = dly_q;
            tap_b = {dly_q, 1'b0};
        end else begin
            tap_a = '0;
            tap_b = {1'b0, dly_q};
        end
    end

    pwm_stagger_dline #(.WIDTH(1), .DEPTH(DEPTH_A), .TAP_W(DLY_W)) u_lane2 (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pdn_all),
        .din   (pwm_in[1]),
        .tap   (tap_a),
        .dout  (lane2_dly)
    );

    pwm_stagger_dline #(.WIDTH(2), .DEPTH(DEPTH_B), .TAP_W(TAP_B_W)) u_pair (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pdn_all),
        .din   (pwm_in[3:2]),
        .tap   (tap_b),
        .dout  (pair_dly)
    );

    assign pwm_out = pdn_all ? 4'b0000 : {pair_dly, lane2_dly, pwm_in[0]};
    assign dly_rd  = dly_q;

    assert_lane1_direct_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pdn_all |-> (pwm_out[0] == pwm_in[0]));

    assert_zero_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!pdn_all && dly_rd == '0) |-> (pwm_out == pwm_in));

    assert_lane2_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pdn_all && mode_q == LANE_2CH) |-> (pwm_out[1] == pwm_in[1]));

endmodule

// File: tb/pwm_edge_stagger_bench.sv
`timescale 1ns/1ps
module pwm_edge_stagger_bench;

    localparam int NV  = 7;
    localparam int RUN = 48;
    localparam int LOCK_V = 5;
    // {mode, setting}
    localparam logic [4:0] VEC [NV] = '{
        5'b0_0000, 5'b0_0001, 5'b0_0111, 5'b0_1111,
        5'b1_0000, 5'b1_0011, 5'b1_1111
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pdn_all = 1'b0;
    logic       mode_3ch = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_data = '0;
    logic [3:0] dly_rd;
    logic [3:0] pwm_in = '0;
    logic [3:0] pwm_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [3:0] hist [RUN];
    logic [7:0] lfsr = 8'h5A;

    always #2.5 clk = ~clk;

    pwm_edge_stagger u_pwm_edge_stagger (
        .clk      (clk),
        .rst_n    (rst_n),
        .pdn_all  (pdn_all),
        .mode_3ch (mode_3ch),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .dly_rd   (dly_rd),
        .pwm_in   (pwm_in),
        .pwm_out  (pwm_out)
    );

    task automatic check(input bit ok, input string req,
                         input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic past_bit(int t, int d, int ch);
        if (t - d < 0) return 1'b0;
        return hist[t-d][ch];
    endfunction

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // Reset state: R1
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(dly_rd == 4'd0, "R1", dly_rd, 4'd0);
        @(posedge clk); #1 pwm_in = 4'b1010;
        @(negedge clk);
        check(pwm_out == 4'b1010, "R1", pwm_out, 4'b1010);
        @(posedge clk); #1 pwm_in = 4'b0101;
        @(negedge clk);
        check(pwm_out == 4'b0101, "R1", pwm_out, 4'b0101);

        for (int v = 0; v < NV; v++) begin
            logic       m;
            logic [3:0] d;
            int d2, d34;
            m = VEC[v][4];
            d = VEC[v][3:0];
            d2  = m ? int'(d) : 0;
            d34 = m ? 2 * int'(d) : int'(d);

            @(posedge clk); #1;
            pdn_all = 1'b1; wr_en = 1'b1; wr_data = d; mode_3ch = m; pwm_in = 4'hF;
            @(posedge clk); #1 wr_en = 1'b0;
            @(negedge clk);
            check(pwm_out == 4'b0000, "R8", pwm_out, 4'b0000);
            check(dly_rd == d, "R5", dly_rd, d);

            @(posedge clk); #1 pdn_all = 1'b0;
            for (int t = 0; t < RUN; t++) begin
                logic [3:0] exp;
                string tag;
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                pwm_in = lfsr[3:0];
                hist[t] = pwm_in;
                if (v == LOCK_V && t == 20) begin
                    wr_en = 1'b1; wr_data = ~d; mode_3ch = ~m;
                end else begin
                    wr_en = 1'b0;
                end
                @(negedge clk);
                exp[0] = past_bit(t, 0, 0);
                exp[1] = past_bit(t, d2, 1);
                exp[2] = past_bit(t, d34, 2);
                exp[3] = past_bit(t, d34, 3);
                if (v == LOCK_V && t > 20)  tag = "R7";
                else if (d == 4'd0)         tag = "R10";
                else if (t < d34)           tag = "R9";
                else if (m)                 tag = "R4";
                else                        tag = "R3";
                check(pwm_out == exp, tag, pwm_out, exp);
                check(pwm_out[0] == pwm_in[0], "R2", {3'b000, pwm_out[0]}, {3'b000, pwm_in[0]});
                @(posedge clk); #1;
            end
            wr_en = 1'b0;
            if (v == LOCK_V) begin
                @(negedge clk);
                check(dly_rd == d, "R6", dly_rd, d);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule